// File: doc/BRIEF.md
# Floating-Point Result Rounder

This block takes a floating-point result that has not yet been rounded and rounds it to the target precision. The result arrives as a sign, a biased exponent, a fraction field without the hidden bit, and three extra low-order bits: guard, round and sticky. A 3-bit mode code selects the rounding rule. The unit returns the rounded sign, exponent and fraction, an inexact flag, and a flag for an unknown mode code. It has one register stage, with a valid strobe going in and coming out.

It sits at the end of a multiply-add datapath, which computes the wide result and normalizes it first. An input exponent of all ones means the exponent has already gone past the largest finite value. When rounding up carries out of the fraction, the hidden bit moves up. The fraction then reads zero and the exponent goes up by one. If that step reaches the all-ones exponent, the result is treated as an exponent overflow.

Top module: `fp_round_unit`

## Requirements
- R1: Mode code 0 rounds to nearest. The result rounds up when guard is set and either round or sticky is set, or the fraction LSB is 1. Guard bit is in_grs[2], round is in_grs[1], sticky is in_grs[0].
- R2: Mode code 1 truncates. The fraction and exponent pass through unchanged whatever the extra bits hold.
- R3: Mode code 2 rounds toward minus infinity. The result rounds up in magnitude only when the sign is 1 and any extra bit is set.
- R4: Mode code 3 rounds toward plus infinity. The result rounds up in magnitude only when the sign is 0 and any extra bit is set.
- R5: Mode code 4 rounds to nearest with ties away from zero. The result rounds up exactly when guard is set.
- R6: Mode codes 5, 6 and 7 produce the following outputs:
  - out_invalid is set and out_inexact is cleared.
  - The output is the canonical quiet NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0.
- R7: For codes 0 to 4, out_inexact is the OR of the three extra bits, ORed with exponent overflow. out_invalid is cleared.
- R8: A round-up of an all-ones fraction gives a zero fraction and an exponent one higher.
- R9: Overflow happens when the input exponent is all ones, or when the R8 increment reaches all ones. The result then depends on the mode:
  - Codes 0 and 4, code 3 with sign 0, and code 2 with sign 1 give infinity: exponent all ones and fraction 0.
  - Code 1, code 2 with sign 0, and code 3 with sign 1 give the largest finite value: exponent all ones minus one and fraction all ones.
- R10: out_valid equals in_valid from one clock earlier. The data outputs update only on a clock where in_valid was 1, and hold otherwise. Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input strobe |
| in_mode | input | 3 | Rounding mode code |
| in_sign | input | 1 | Sign of the unrounded value |
| in_exp | input | EXP_W | Biased exponent; all ones means already out of range |
| in_frac | input | FRAC_W | Fraction field without hidden bit |
| in_grs | input | 3 | Guard, round and sticky bits |
| out_valid | output | 1 | Output strobe |
| out_sign | output | 1 | Rounded sign |
| out_exp | output | EXP_W | Rounded exponent |
| out_frac | output | FRAC_W | Rounded fraction |
| out_inexact | output | 1 | Result differs from the exact value |
| out_invalid | output | 1 | Mode code was reserved |

## Verification
Two functions can fall in the same cycle: the carry renormalization and the exponent overflow. An all-ones fraction with an exponent one below all ones, when it rounds up, carries into the exponent and reaches the overflow code in that single cycle. The bench applies this input with a tie under mode 0 and expects infinity, not a zero-fraction number with the all-ones exponent. It also applies a carry with an ordinary exponent, which must give a plain increment.

// File: rtl/fp_round_unit.sv
module fp_round_unit #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_mode,
  input  logic              in_sign,
  input  logic [EXP_W-1:0]  in_exp,
  input  logic [FRAC_W-1:0] in_frac,
  input  logic [2:0]        in_grs,
  output logic              out_valid,
  output logic              out_sign,
  output logic [EXP_W-1:0]  out_exp,
  output logic [FRAC_W-1:0] out_frac,
  output logic              out_inexact,
  output logic              out_invalid
);
  localparam logic [EXP_W-1:0]  EMAX  = '1;
  localparam logic [EXP_W-1:0]  EBIG  = EMAX - 1'b1;
  localparam logic [FRAC_W-1:0] FMAX  = '1;
  localparam logic [FRAC_W-1:0] QNANF = {1'b1, {(FRAC_W-1){1'b0}}};

  logic              any_x, up, to_inf, bad_mode, carry, ovf;
  logic [FRAC_W-1:0] frac_up;
  logic [EXP_W-1:0]  exp_up;

  assign any_x    = |in_grs;
  assign bad_mode = in_mode > 3'd4;

  always_comb begin
    case (in_mode)
      3'd0:    up = in_grs[2] & (in_grs[1] | in_grs[0] | in_frac[0]);
      3'd2:    up = in_sign & any_x;
      3'd3:    up = ~in_sign & any_x;
      3'd4:    up = in_grs[2];
      default: up = 1'b0;
    endcase
  end

  always_comb begin
    case (in_mode)
      3'd1:    to_inf = 1'b0;
      3'd2:    to_inf = in_sign;
      3'd3:    to_inf = ~in_sign;
      default: to_inf = 1'b1;
    endcase
  end

  assign {carry, frac_up} = {1'b0, in_frac} + {{FRAC_W{1'b0}}, up};
  assign exp_up = in_exp + {{(EXP_W-1){1'b0}}, carry};
  assign ovf    = (in_exp == EMAX) || (exp_up == EMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sign    <= 1'b0;
      out_exp     <= '0;
      out_frac    <= '0;
      out_inexact <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        if (bad_mode) begin
          out_sign    <= 1'b0;
          out_exp     <= EMAX;
          out_frac    <= QNANF;
          out_inexact <= 1'b0;
          out_invalid <= 1'b1;
        end else begin
          out_sign    <= in_sign;
          out_inexact <= any_x | ovf;
          out_invalid <= 1'b0;
          if (ovf) begin
            out_exp  <= to_inf ? EMAX : EBIG;
            out_frac <= to_inf ? '0 : FMAX;
          end else begin
            out_exp  <= exp_up;
            out_frac <= frac_up;
          end
        end
      end
    end
  end

  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_exp) && $stable(out_frac));
  p_qnan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode > 3'd4) |=> out_invalid && !out_inexact && out_exp == EMAX && out_frac == QNANF);
  p_inexact_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode <= 3'd4 && in_exp != EMAX) |=> out_inexact == $past(|in_grs) || out_exp == EMAX);
  p_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode == 3'd1 && in_exp != EMAX) |=> out_frac == $past(in_frac) && out_exp == $past(in_exp));
  p_no_nan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_exp == EMAX && !out_invalid) |-> out_frac == '0);
endmodule

// File: tb/fp_round_unit_tb.sv
module fp_round_unit_tb;
  localparam int CLK_NS = 10;
  localparam int EW = 8;
  localparam int FW = 23;

  typedef struct packed {
    logic [3:0]    req;
    logic [2:0]    mode;
    logic          sign;
    logic [EW-1:0] exp;
    logic [FW-1:0] frac;
    logic [2:0]    grs;
    logic          xsign;
    logic [EW-1:0] xexp;
    logic [FW-1:0] xfrac;
    logic          xinx;
    logic          xinv;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [0:NV-1] = '{
    '{4'd1, 3'd0, 1'b0, 8'h80, 23'h10,     3'b100, 1'b0, 8'h80, 23'h10,     1'b1, 1'b0}, // R1 tie, even stays
    '{4'd1, 3'd0, 1'b0, 8'h80, 23'h11,     3'b100, 1'b0, 8'h80, 23'h12,     1'b1, 1'b0}, // R1 tie, odd up
    '{4'd1, 3'd0, 1'b1, 8'h80, 23'h10,     3'b101, 1'b1, 8'h80, 23'h11,     1'b1, 1'b0}, // R1 above half
    '{4'd1, 3'd0, 1'b0, 8'h80, 23'h11,     3'b011, 1'b0, 8'h80, 23'h11,     1'b1, 1'b0}, // R1 below half
    '{4'd2, 3'd1, 1'b0, 8'h80, 23'h11,     3'b111, 1'b0, 8'h80, 23'h11,     1'b1, 1'b0}, // R2
    '{4'd2, 3'd1, 1'b1, 8'h40, 23'h7FFFFF, 3'b110, 1'b1, 8'h40, 23'h7FFFFF, 1'b1, 1'b0}, // R2 no carry
    '{4'd3, 3'd2, 1'b0, 8'h80, 23'h11,     3'b001, 1'b0, 8'h80, 23'h11,     1'b1, 1'b0}, // R3 positive
    '{4'd3, 3'd2, 1'b1, 8'h80, 23'h11,     3'b001, 1'b1, 8'h80, 23'h12,     1'b1, 1'b0}, // R3 negative
    '{4'd4, 3'd3, 1'b0, 8'h80, 23'h10,     3'b001, 1'b0, 8'h80, 23'h11,     1'b1, 1'b0}, // R4 positive
    '{4'd4, 3'd3, 1'b1, 8'h80, 23'h10,     3'b111, 1'b1, 8'h80, 23'h10,     1'b1, 1'b0}, // R4 negative
    '{4'd5, 3'd4, 1'b0, 8'h80, 23'h10,     3'b100, 1'b0, 8'h80, 23'h11,     1'b1, 1'b0}, // R5 tie away
    '{4'd5, 3'd4, 1'b1, 8'h80, 23'h10,     3'b011, 1'b1, 8'h80, 23'h10,     1'b1, 1'b0}, // R5 below half
    '{4'd7, 3'd0, 1'b0, 8'h80, 23'h10,     3'b000, 1'b0, 8'h80, 23'h10,     1'b0, 1'b0}, // R7 exact
    '{4'd7, 3'd3, 1'b0, 8'h80, 23'h10,     3'b000, 1'b0, 8'h80, 23'h10,     1'b0, 1'b0}, // R7 exact directed
    '{4'd6, 3'd5, 1'b1, 8'h80, 23'h10,     3'b111, 1'b0, 8'hFF, 23'h400000, 1'b0, 1'b1}, // R6
    '{4'd6, 3'd6, 1'b0, 8'h10, 23'h0,      3'b000, 1'b0, 8'hFF, 23'h400000, 1'b0, 1'b1}, // R6
    '{4'd6, 3'd7, 1'b1, 8'hFF, 23'h7FFFFF, 3'b100, 1'b0, 8'hFF, 23'h400000, 1'b0, 1'b1}, // R6
    '{4'd8, 3'd0, 1'b0, 8'h80, 23'h7FFFFF, 3'b110, 1'b0, 8'h81, 23'h0,      1'b1, 1'b0}, // R8
    '{4'd8, 3'd3, 1'b0, 8'h01, 23'h7FFFFF, 3'b001, 1'b0, 8'h02, 23'h0,      1'b1, 1'b0}, // R8
    '{4'd9, 3'd0, 1'b0, 8'hFE, 23'h7FFFFF, 3'b100, 1'b0, 8'hFF, 23'h0,      1'b1, 1'b0}, // R9 carry+ovf
    '{4'd9, 3'd1, 1'b0, 8'hFF, 23'h0,      3'b000, 1'b0, 8'hFE, 23'h7FFFFF, 1'b1, 1'b0}, // R9
    '{4'd9, 3'd2, 1'b0, 8'hFF, 23'h0,      3'b000, 1'b0, 8'hFE, 23'h7FFFFF, 1'b1, 1'b0}, // R9
    '{4'd9, 3'd2, 1'b1, 8'hFF, 23'h0,      3'b000, 1'b1, 8'hFF, 23'h0,      1'b1, 1'b0}, // R9
    '{4'd9, 3'd3, 1'b1, 8'hFF, 23'h0,      3'b000, 1'b1, 8'hFE, 23'h7FFFFF, 1'b1, 1'b0}, // R9
    '{4'd9, 3'd3, 1'b0, 8'hFF, 23'h5,      3'b010, 1'b0, 8'hFF, 23'h0,      1'b1, 1'b0}, // R9
    '{4'd9, 3'd4, 1'b1, 8'hFF, 23'h0,      3'b000, 1'b1, 8'hFF, 23'h0,      1'b1, 1'b0}, // R9
    '{4'd9, 3'd1, 1'b1, 8'hFE, 23'h7FFFFF, 3'b111, 1'b1, 8'hFE, 23'h7FFFFF, 1'b1, 1'b0}, // R9 no carry
    '{4'd9, 3'd3, 1'b0, 8'hFE, 23'h7FFFFF, 3'b001, 1'b0, 8'hFF, 23'h0,      1'b1, 1'b0}  // R9 carry+ovf
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_sign = 1'b0;
  logic [2:0] in_mode = '0, in_grs = '0;
  logic [EW-1:0] in_exp = '0;
  logic [FW-1:0] in_frac = '0;
  logic out_valid, out_sign, out_inexact, out_invalid;
  logic [EW-1:0] out_exp;
  logic [FW-1:0] out_frac;
  int total = 0, bad = 0;
  logic [EW-1:0] held_e;
  logic [FW-1:0] held_f;

  always #(CLK_NS/2) clk = ~clk;

  fp_round_unit #(.EXP_W(EW), .FRAC_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
    .in_sign(in_sign), .in_exp(in_exp), .in_frac(in_frac), .in_grs(in_grs),
    .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
    .out_frac(out_frac), .out_inexact(out_inexact), .out_invalid(out_invalid));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  initial begin
    #(CLK_NS * 20000);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset valid", 64'(out_valid), 64'd0);
    chk("R10 reset exp", 64'(out_exp), 64'd0);
    chk("R10 reset flags", 64'({out_inexact, out_invalid}), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_mode = TBL[i].mode; in_sign = TBL[i].sign; in_exp = TBL[i].exp;
      in_frac = TBL[i].frac; in_grs = TBL[i].grs;
      @(negedge clk);
      in_valid = 1'b0;
      chk($sformatf("R%0d vec%0d valid", TBL[i].req, i), 64'(out_valid), 64'd1);
      chk($sformatf("R%0d vec%0d result", TBL[i].req, i),
          64'({out_sign, out_exp, out_frac, out_inexact, out_invalid}),
          64'({TBL[i].xsign, TBL[i].xexp, TBL[i].xfrac, TBL[i].xinx, TBL[i].xinv}));
    end
    // R10 hold when in_valid low, then latency
    @(negedge clk);
    chk("R10 valid drops", 64'(out_valid), 64'd0);
    held_e = out_exp; held_f = out_frac;
    in_mode = 3'd0; in_exp = 8'h33; in_frac = 23'h123; in_grs = 3'b111;
    @(negedge clk);
    chk("R10 hold exp", 64'(out_exp), 64'(held_e));
    chk("R10 hold frac", 64'(out_frac), 64'(held_f));
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10 one-cycle latency", 64'({out_valid, out_exp, out_frac}), 64'({1'b1, 8'h33, 23'h124}));
    @(negedge clk);
    chk("R10 single pulse", 64'(out_valid), 64'd0);
    // R10 reset mid-run clears
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset clears", 64'({out_valid, out_exp, out_frac}), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule